// File: doc/BRIEF.md
# Handshaked Byte Input Port

This block is an 8-bit input port that sits behind a byte-wide register interface. An external peripheral places a byte on the input pins and pulses a strobe line. The port answers on a ready line that tells the peripheral whether another byte can be taken. Software sees five registers: global control, port control, pin direction, data and status.

Two input flavours are selectable. In buffered mode each strobe edge captures the pins into a two-deep queue, and a data read pops the oldest byte. In live mode the data register shows the pins as they are at the moment of the read, and strobes capture nothing. The status register records strobe activity and overruns in sticky bits that software clears by writing ones. It also shows the current fill and ready levels.

The strobe line is asynchronous. It passes through a two-stage synchroniser, and only its rising edge acts.

Top module: `hs_par_in_port`

## Requirements
- R1: After reset every register reads 0x00 and `ready_o` is low.
- R2: Global control (offset 0x00), direction (0x04) and port control (0x0C) read back the last value written. Any offset outside the five mapped ones reads 0x00.
- R3: Global control bit 4 enables the strobe/ready pair. While it is 0, strobes capture nothing and set no status, `ready_o` stays low and the queue is empty.
- R4: In buffered mode (port control bit 7 = 0), a rising strobe edge captures the pins no later than the third clock edge after the rise. Later pin changes do not alter the held byte.
- R5: A read of the data register (0x10) in buffered mode returns the oldest held byte and moves the second byte up, so bytes come out in arrival order.
- R6: With two bytes held, `ready_o` is low from the next clock on. Further strobes are dropped and set status bit 1 (overrun).
- R7: After a data read frees a stage, `ready_o` is still low in the cycle right after the read and is high one clock later.
- R8: In live mode (port control bit 7 = 1), a data read returns the current pin levels. Strobes capture nothing, the queue is emptied, status bit 4 reads 0, and `ready_o` is high while the port is enabled.
- R9: Data bits whose direction bit is 1 read as 0 in both modes.
- R10: The status register at 0x1A holds: bit 0 sticky strobe-seen, set on any enabled strobe edge; bit 1 sticky overrun; bit 4 set when the queue is not empty; bit 5 equal to `ready_o`. Writing 1 to bit 0 or bit 1 clears that bit, and writing 0 leaves it unchanged.
- R11: A data read in buffered mode with an empty queue returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Register byte offset |
| wr_i | input | 1 | Register write strobe, one cycle |
| rd_i | input | 1 | Register read strobe, one cycle (pops data) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| pins_i | input | 8 | Peripheral data pins |
| strobe_i | input | 1 | Peripheral strobe, asynchronous |
| ready_o | output | 1 | Port can accept another byte |

## Verification
A fill count that has drifted shows up on the next data or status read. The symptoms are bytes out of order, a byte that repeats, or a stale byte where 0x00 is expected. The same fault makes `ready_o` wrong one clock after the count goes wrong. A broken synchroniser or edge detector appears within three clocks of the strobe rise: status bit 0 does not set, or a single pulse captures two bytes. A wrong mode or enable decode appears at once in live-pin reads and in the ready level.

// File: rtl/hs_pkg.sv
package hs_pkg;
  localparam int unsigned ADDR_W   = 5;
  localparam int unsigned DATA_W   = 8;

  localparam logic [ADDR_W-1:0] OFS_GCTRL = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_DIR   = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_PCTRL = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_DATA  = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 5'h1A;

  localparam int unsigned GC_HS_EN  = 4;
  localparam int unsigned PC_LIVE   = 7;

  localparam int unsigned ST_STB    = 0;
  localparam int unsigned ST_OVR    = 1;
  localparam int unsigned ST_AVAIL  = 4;
  localparam int unsigned ST_READY  = 5;
endpackage

// File: rtl/hs_strobe_sync.sv
module hs_strobe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], strobe_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  AST_EDGE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R4
endmodule

// File: rtl/hs_in_buffer.sv
module hs_in_buffer #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [WIDTH-1:0] st0_q, st1_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign do_push = push_i && (cnt_q != 2'd2);
  assign do_pop  = pop_i && (cnt_q != 2'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st0_q <= '0;
      st1_q <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      cnt_q <= '0;
    end else begin
      unique case ({do_push, do_pop})
        2'b10: begin
          if (cnt_q == 2'd0) st0_q <= din_i;
          else               st1_q <= din_i;
          cnt_q <= cnt_q + 2'd1;
        end
        2'b01: begin
          st0_q <= st1_q;
          cnt_q <= cnt_q - 2'd1;
        end
        2'b11: begin
          // count is 1 here: new byte becomes head
          st0_q <= din_i;
        end
        default: ;
      endcase
    end
  end

  assign head_o = (cnt_q != 2'd0) ? st0_q : '0;
  assign cnt_o  = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == 2'd2 && !pop_i && !flush_i) |=> cnt_q == 2'd2); // R6
  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> cnt_q == 2'd0); // R8
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q != 2'd3); // R5
endmodule

// File: rtl/hs_par_in_port.sv
module hs_par_in_port
  import hs_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] pins_i,
  input  logic              strobe_i,
  output logic              ready_o
);
  logic [DATA_W-1:0] gctrl_q, pctrl_q, dir_q;
  logic              stb_seen_q, ovr_q, ready_q;
  logic              rise, hs_en, live, flush, push, pop;
  logic [DATA_W-1:0] head;
  logic [1:0]        cnt;
  logic [DATA_W-1:0] stat;
  logic              wr_stat;

  hs_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (strobe_i),
    .rise_o   (rise)
  );

  assign hs_en = gctrl_q[GC_HS_EN];
  assign live  = pctrl_q[PC_LIVE];
  assign flush = !hs_en || live;
  assign push  = rise && hs_en && !live;
  assign pop   = rd_i && (addr_i == OFS_DATA) && hs_en && !live;

  hs_in_buffer #(.WIDTH(DATA_W)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .push_i  (push),
    .din_i   (pins_i),
    .pop_i   (pop),
    .head_o  (head),
    .cnt_o   (cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gctrl_q <= '0;
      pctrl_q <= '0;
      dir_q   <= '0;
    end else if (wr_i) begin
      if (addr_i == OFS_GCTRL) gctrl_q <= wdata_i;
      if (addr_i == OFS_PCTRL) pctrl_q <= wdata_i;
      if (addr_i == OFS_DIR)   dir_q   <= wdata_i;
    end
  end

  assign wr_stat = wr_i && (addr_i == OFS_STAT);

  // sticky bits: set beats clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_seen_q <= 1'b0;
      ovr_q      <= 1'b0;
      ready_q    <= 1'b0;
    end else begin
      stb_seen_q <= (stb_seen_q && !(wr_stat && wdata_i[ST_STB])) || (rise && hs_en);
      ovr_q      <= (ovr_q && !(wr_stat && wdata_i[ST_OVR])) || (push && cnt == 2'd2);
      ready_q    <= hs_en && (live || cnt != 2'd2);
    end
  end

  assign ready_o = ready_q;

  always_comb begin
    stat           = '0;
    stat[ST_STB]   = stb_seen_q;
    stat[ST_OVR]   = ovr_q;
    stat[ST_AVAIL] = (cnt != 2'd0);
    stat[ST_READY] = ready_q;
  end

  always_comb begin
    unique case (addr_i)
      OFS_GCTRL: rdata_o = gctrl_q;
      OFS_DIR:   rdata_o = dir_q;
      OFS_PCTRL: rdata_o = pctrl_q;
      OFS_DATA:  rdata_o = (live ? pins_i : head) & ~dir_q;
      OFS_STAT:  rdata_o = stat;
      default:   rdata_o = '0;
    endcase
  end

  AST_READY_LOW_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == 2'd2) |=> !ready_o); // R6
  AST_STB_SEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && hs_en) |=> stb_seen_q); // R10
  AST_DIS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hs_en && $past(!hs_en)) |-> (!ready_o && cnt == 2'd0)); // R3
  AST_LIVE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_en && live) |=> (ready_o || !hs_en)); // R8
endmodule

// File: tb/hs_par_in_port_tb_top.sv
module hs_par_in_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0, rdata, pins = '0;
  logic       strobe = 1'b0, ready;
  int         n_run = 0, n_fail = 0, cyc = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  hs_par_in_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .pins_i(pins), .strobe_i(strobe),
    .ready_o(ready)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(logic [4:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic pulse(logic [7:0] d);
    @(negedge clk); pins = d; strobe = 1'b1;
    repeat (4) @(negedge clk);
    strobe = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 ready", {7'd0, ready}, 8'h00);
    bus_rd(5'h00, v); check("R1 gctrl", v, 8'h00);
    bus_rd(5'h04, v); check("R1 dir", v, 8'h00);
    bus_rd(5'h0C, v); check("R1 pctrl", v, 8'h00);
    bus_rd(5'h10, v); check("R1 data", v, 8'h00);
    bus_rd(5'h1A, v); check("R1 stat", v, 8'h00);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    bus_wr(5'h04, 8'h5C); bus_rd(5'h04, v); check("R2 dir", v, 8'h5C);
    bus_wr(5'h0C, 8'h03); bus_rd(5'h0C, v); check("R2 pctrl", v, 8'h03);
    bus_wr(5'h00, 8'h0A); bus_rd(5'h00, v); check("R2 gctrl", v, 8'h0A);
    bus_rd(5'h02, v); check("R2 unmapped", v, 8'h00);
    bus_wr(5'h04, 8'h00); bus_wr(5'h0C, 8'h00);
  endtask

  task automatic t_disabled();
    logic [7:0] v;
    bus_wr(5'h00, 8'h00);
    pulse(8'h77);
    bus_rd(5'h1A, v); check("R3 stat", v, 8'h00);
    check("R3 ready", {7'd0, ready}, 8'h00);
    bus_rd(5'h10, v); check("R3 data", v, 8'h00);
  endtask

  task automatic t_buffered();
    logic [7:0] v;
    bus_wr(5'h00, 8'h30);
    @(negedge clk);
    check("R3 ready on", {7'd0, ready}, 8'h01);
    pulse(8'hA5); pins = 8'h00;
    bus_rd(5'h1A, v); check("R10 stat one", v, 8'h31);
    bus_wr(5'h1A, 8'h00);
    bus_rd(5'h1A, v); check("R10 w0 keep", v, 8'h31);
    bus_wr(5'h1A, 8'h01);
    bus_rd(5'h1A, v); check("R10 w1 clr", v, 8'h30);
    pulse(8'h3C);
    check("R6 ready low", {7'd0, ready}, 8'h00);
    pulse(8'hFF);
    bus_rd(5'h1A, v); check("R6 ovr", v, 8'h13);
    bus_rd(5'h10, v); check("R4 R5 first", v, 8'hA5);
    check("R7 ready still low", {7'd0, ready}, 8'h00);
    @(negedge clk);
    check("R7 ready back", {7'd0, ready}, 8'h01);
    bus_rd(5'h10, v); check("R5 second", v, 8'h3C);
    bus_rd(5'h10, v); check("R11 empty", v, 8'h00);
    bus_wr(5'h1A, 8'h03);
    bus_rd(5'h1A, v); check("R10 clr both", v, 8'h20);
  endtask

  task automatic t_mask();
    logic [7:0] v;
    bus_wr(5'h04, 8'hF0);
    pulse(8'hFF);
    bus_rd(5'h10, v); check("R9 buffered", v, 8'h0F);
    pins = 8'hC3; bus_wr(5'h0C, 8'h80);
    bus_rd(5'h10, v); check("R9 live", v, 8'h03);
    bus_wr(5'h04, 8'h00); bus_wr(5'h0C, 8'h00);
  endtask

  task automatic t_live();
    logic [7:0] v;
    pulse(8'h44);
    bus_wr(5'h0C, 8'h80);
    bus_wr(5'h1A, 8'h03);
    pins = 8'h5A;
    bus_rd(5'h10, v); check("R8 pins", v, 8'h5A);
    pulse(8'h11); pins = 8'h22;
    bus_rd(5'h10, v); check("R8 live follow", v, 8'h22);
    bus_rd(5'h1A, v); check("R8 stat", v, 8'h21);
    check("R8 ready", {7'd0, ready}, 8'h01);
    bus_wr(5'h0C, 8'h00);
    bus_rd(5'h10, v); check("R8 flushed", v, 8'h00);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_disabled();
    t_buffered();
    t_mask();
    t_live();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule